// File: doc/BRIEF.md
# GPIO Interrupt Mask and Status Unit

This unit collects interrupt events for an eight-pin general-purpose I/O port and turns them into one interrupt request for the system interrupt controller. An upstream detector, outside this block, decides when a pin has an interrupt condition and pulses one strobe bit for that pin. The unit records each pulse in a sticky per-pin pending bit. Software then sees the pending bits, either raw or filtered through a per-pin enable mask, over a small word-wide register bus.

Pending bits never clear by themselves. Software acknowledges events by writing ones to a write-only acknowledge register, and each one clears the matching pending bit. If an event arrives in the same cycle that software acknowledges that bit, the event is kept. The interrupt request is the registered OR of all pending-and-enabled pins. It follows a change of pending or enable state with one clock of delay.

The bus is a plain synchronous write strobe with a combinational read path. Reads return the register chosen by the present address. Writes take effect at the next rising clock edge.

Top module: `gpio_irq_agg`

## Requirements
- R1: The enable register at address 0x410 holds pin enables in bits 7:0, where bit i belongs to pin i. It is written whenever `bus_we` is high with that address, and reads back exactly what was written there. Bits 31:8 of every read are zero.
- R2: After reset the enable register, the pending register and `irq_out` are all zero.
- R3: A high `cond_stb[i]` at a clock edge sets pending bit i at that edge, whatever the enable bit for pin i holds. The pending register reads at 0x414 with bit i for pin i. A pending bit never sets without a strobe.
- R4: A pending bit stays set until a write to the acknowledge register at 0x41C has a 1 in that bit position. Bits written as 0 there leave the pending bits unchanged.
- R5: A read at 0x418 returns the bitwise AND of the pending and enable registers.
- R6: `irq_out` is high in the cycle after one in which some pin had both its pending bit and its enable bit set. It is low in the cycle after one in which no pin did.
- R7: If a strobe and an acknowledge write with a 1 hit the same bit in the same cycle, the pending bit is set after that edge.
- R8: Writes to 0x414 and 0x418 change no state. The acknowledge register at 0x41C reads as zero, and so does any address not named here.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| cond_stb | input | 8 | One-cycle interrupt-condition strobe per pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the present address |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The embedded assertions check on every cycle that pending bits hold until acknowledged, that they set only on a strobe, that a strobe wins over a same-cycle acknowledge, that the enable register stays unchanged without a write, and that the request line tracks the pending-and-enabled state with one clock of lag. Reserved bits and the acknowledge register's read value are also checked on every cycle. The address map and register contents can be shown only by the bench's scenarios: which offset holds which register, that writes to the status addresses are dropped, that a zero acknowledge does nothing, and the exact cycle in which the request rises and falls after a change to the enable register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFS_ENABLE  = 'h410;
  localparam int OFS_PENDING = 'h414;
  localparam int OFS_ACTIVE  = 'h418;
  localparam int OFS_ACK     = 'h41C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_PENDING,
    SEL_ACTIVE,
    SEL_ACK
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] mask_o
);
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] mask_d;

  always_comb mask_d = wr_en ? wr_data : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R1: without a write the enables are untouched
  assert_mask_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] cond_stb_i,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] pend_q;
  logic [NUM_PINS-1:0] pend_d;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_bit
    always_comb pend_d[g] = cond_stb_i[g] | (pend_q[g] & ~ack_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end
  end

  assign pend_o = pend_q;

  // R4: a pending bit with no acknowledge stays set
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(ack_i) & ~pend_q) == '0));

  // R7: a strobe always leaves its bit set, even against an acknowledge
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|cond_stb_i) |=> (($past(cond_stb_i) & ~pend_q) == '0));

  // R3: no bit rises without a strobe
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(cond_stb_i)) == '0));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic                irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb irq_d = |(pend_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R6: request follows an enabled pending pin one cycle later
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_i & mask_i)) |=> irq_q);

  // R6: request is never high without an enabled pending pin the cycle before
  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|(pend_i & mask_i)));
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] cond_stb,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_out
);
  localparam int SPARE_W = DATA_W - NUM_PINS;

  logic                rst_n_sync;
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] ack_vec;
  logic [NUM_PINS-1:0] rd_bits;
  logic                mask_we;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_ENABLE))  sel = SEL_ENABLE;
    else if (bus_addr == ADDR_W'(OFS_PENDING)) sel = SEL_PENDING;
    else if (bus_addr == ADDR_W'(OFS_ACTIVE))  sel = SEL_ACTIVE;
    else if (bus_addr == ADDR_W'(OFS_ACK))     sel = SEL_ACK;
    else                                       sel = SEL_NONE;
  end

  assign mask_we = bus_we && (sel == SEL_ENABLE);
  assign ack_vec = (bus_we && (sel == SEL_ACK)) ? bus_wdata[NUM_PINS-1:0] : '0;

  irq_mask_reg #(.NUM_PINS(NUM_PINS)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (mask_we),
    .wr_data (bus_wdata[NUM_PINS-1:0]),
    .mask_o  (mask)
  );

  irq_status_bank #(.NUM_PINS(NUM_PINS)) u_status (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cond_stb_i (cond_stb),
    .ack_i      (ack_vec),
    .pend_o     (pend)
  );

  irq_combine #(.NUM_PINS(NUM_PINS)) u_combine (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .pend_i (pend),
    .mask_i (mask),
    .irq_o  (irq_out)
  );

  always_comb begin
    unique case (sel)
      SEL_ENABLE:  rd_bits = mask;
      SEL_PENDING: rd_bits = pend;
      SEL_ACTIVE:  rd_bits = pend & mask;
      default:     rd_bits = '0;
    endcase
  end

  assign bus_rdata = {{SPARE_W{1'b0}}, rd_bits};

  // R1: reserved upper bits never carry data
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    bus_rdata[DATA_W-1:NUM_PINS] == '0);

  // R8: the acknowledge register reads as zero
  assert_ack_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_addr == ADDR_W'(OFS_ACK)) |-> (bus_rdata == '0));

  // R5: active view never shows a disabled pin
  assert_active_subset_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_addr == ADDR_W'(OFS_ACTIVE)) |-> ((bus_rdata[NUM_PINS-1:0] & ~mask) == '0));
endmodule

// File: tb/gpio_irq_agg_tb.sv
`timescale 1ns/1ps
module gpio_irq_agg_tb;
  localparam real PERIOD = 8.0;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cond_stb;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks;
  int failures;

  bit [7:0] m_mask;
  bit [7:0] m_raw;
  bit       m_irq;

  gpio_irq_agg u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_stb  (cond_stb),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // behavioural reference, updated from the values present at each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 8'h00;
      m_raw  = 8'h00;
      m_irq  = 1'b0;
    end else begin
      bit [7:0] clr;
      m_irq = (m_raw & m_mask) != 8'h00;
      clr = (bus_we && bus_addr == 12'h41C) ? bus_wdata[7:0] : 8'h00;
      m_raw = (m_raw & ~clr) | cond_stb;
      if (bus_we && bus_addr == 12'h410) m_mask = bus_wdata[7:0];
    end
  end

  function automatic bit [31:0] model_read(input bit [11:0] a);
    case (a)
      12'h410: return {24'h0, m_mask};
      12'h414: return {24'h0, m_raw};
      12'h418: return {24'h0, m_raw & m_mask};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    string tag;
    case (bus_addr)
      12'h410: tag = "R1";
      12'h414: tag = "R3";
      12'h418: tag = "R5";
      default: tag = "R8";
    endcase
    check(bus_rdata === model_read(bus_addr), tag, bus_rdata, model_read(bus_addr));
    check(irq_out === m_irq, "R6", {31'h0, irq_out}, {31'h0, m_irq});
  endtask

  // apply inputs for one clock, then compare after the edge
  task automatic step(input bit [7:0] stb, input bit we, input bit [11:0] a,
                      input bit [31:0] d);
    cond_stb  = stb;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_read(input bit [11:0] a);
    step(8'h00, 1'b0, a, 32'h0);
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    cond_stb = '0; bus_we = 1'b0; bus_addr = 12'h410; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    idle_read(12'h410); check(bus_rdata == 32'h0, "R2", bus_rdata, 32'h0);
    idle_read(12'h414); check(bus_rdata == 32'h0, "R2", bus_rdata, 32'h0);
    check(irq_out == 1'b0, "R2", {31'h0, irq_out}, 32'h0);

    // R1: enable write and reserved bits
    step(8'h00, 1'b1, 12'h410, 32'hFFFF_FFFF);
    idle_read(12'h410); check(bus_rdata == 32'h0000_00FF, "R1", bus_rdata, 32'hFF);
    step(8'h00, 1'b1, 12'h410, 32'h0000_0005);
    idle_read(12'h410); check(bus_rdata == 32'h5, "R1", bus_rdata, 32'h5);

    // R3: disabled pin still latches, no request
    step(8'h02, 1'b0, 12'h414, 32'h0);
    check(bus_rdata == 32'h02, "R3", bus_rdata, 32'h02);
    idle_read(12'h418); check(bus_rdata == 32'h0, "R5", bus_rdata, 32'h0);
    check(irq_out == 1'b0, "R6", {31'h0, irq_out}, 32'h0);

    // R6: enabled pin raises the request one cycle late
    step(8'h01, 1'b0, 12'h418, 32'h0);
    check(bus_rdata == 32'h01, "R5", bus_rdata, 32'h01);
    check(irq_out == 1'b0, "R6", {31'h0, irq_out}, 32'h0);
    idle_read(12'h414);
    check(irq_out == 1'b1, "R6", {31'h0, irq_out}, 32'h1);
    check(bus_rdata == 32'h03, "R3", bus_rdata, 32'h03);

    // R4: zero acknowledge does nothing; R8: status writes dropped
    step(8'h00, 1'b1, 12'h41C, 32'h0);
    step(8'h00, 1'b1, 12'h414, 32'h0);
    step(8'h00, 1'b1, 12'h418, 32'h0);
    idle_read(12'h414); check(bus_rdata == 32'h03, "R4", bus_rdata, 32'h03);
    idle_read(12'h410); check(bus_rdata == 32'h05, "R8", bus_rdata, 32'h05);
    idle_read(12'h41C); check(bus_rdata == 32'h0, "R8", bus_rdata, 32'h0);
    idle_read(12'h420); check(bus_rdata == 32'h0, "R8", bus_rdata, 32'h0);

    // R4: acknowledge pin 0 drops request one cycle later
    step(8'h00, 1'b1, 12'h41C, 32'h1);
    check(irq_out == 1'b1, "R6", {31'h0, irq_out}, 32'h1);
    idle_read(12'h414);
    check(bus_rdata == 32'h02, "R4", bus_rdata, 32'h02);
    check(irq_out == 1'b0, "R6", {31'h0, irq_out}, 32'h0);

    // R7: strobe and acknowledge on the same bit
    step(8'h02, 1'b1, 12'h41C, 32'h2);
    idle_read(12'h414); check(bus_rdata == 32'h02, "R7", bus_rdata, 32'h02);

    // R6: enable change alone moves the request
    step(8'h00, 1'b1, 12'h410, 32'h2);
    check(irq_out == 1'b0, "R6", {31'h0, irq_out}, 32'h0);
    idle_read(12'h418);
    check(irq_out == 1'b1, "R6", {31'h0, irq_out}, 32'h1);
    step(8'h00, 1'b1, 12'h410, 32'h0);
    idle_read(12'h418);
    check(irq_out == 1'b0, "R6", {31'h0, irq_out}, 32'h0);

    // R3/R4: several pins, then clear all
    step(8'hA0, 1'b0, 12'h414, 32'h0);
    check(bus_rdata == 32'hA2, "R3", bus_rdata, 32'hA2);
    step(8'h00, 1'b1, 12'h41C, 32'hFF);
    idle_read(12'h414); check(bus_rdata == 32'h0, "R4", bus_rdata, 32'h0);

    // sweep: every pin alone, enabled
    step(8'h00, 1'b1, 12'h410, 32'hFF);
    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 1'b0, 12'h418, 32'h0);
      check(bus_rdata == 32'(1 << i), "R5", bus_rdata, 32'(1 << i));
      step(8'h00, 1'b1, 12'h41C, 32'(1 << i));
      check(irq_out == 1'b1, "R6", {31'h0, irq_out}, 32'h1);
      idle_read(12'h414);
    end
    idle_read(12'h414);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule